// File: doc/BRIEF.md
# Variable-Length Instruction Length Predecoder

This block sits in an instruction fetch path where a compact instruction set mixes 2-, 4- and 6-byte instructions. Each cycle it looks at a window of up to six bytes taken from the head of the fetched byte stream, together with a count of how many of those bytes are valid. From the leading halfword it works out how long the instruction is. It then assembles the complete instruction word and tags it with the decoder that must handle it: compact 16-bit, compact 32-bit, base 32-bit call format, or compact 48-bit.

The result leaves on a valid/ready handshake. When the consumer accepts, the block reports how many bytes the fetch logic must retire from the head of its stream, and this is always exactly the decoded length. When the window holds fewer bytes than the instruction needs, the block raises a truncation flag. It then reports length zero and retires nothing, so fetch can wait for more bytes.

Top module: `vlp_predecode`

## Requirements
- R1: When bits 15:14 of the leading halfword (first window byte = bits 15:8) equal 1, the length is 4 bytes.
- R2: When bits 15:14 equal 0, the length is 4 bytes if bit 9 is 1 and 2 bytes if bit 9 is 0.
- R3: When bits 15:14 equal 2 or 3, the length is 4 bytes if bits 8:5 equal 7, and 6 bytes if bits 8:5 equal 15.
- R4: When bits 15:14 equal 2 or 3 and bits 8:5 are neither 7 nor 15, the length is 2 bytes.
- R5: `out_class` is 0 for a 2-byte and 3 for a 6-byte instruction. A 4-byte word whose bits 31:30 are 01 gets class 2 (base call format). Every other 4-byte word gets class 1.
- R6: `out_word` holds the instruction right-aligned, with the first window byte as its most significant byte. The bits above the instruction length are zero.
- R7: When the valid count is below 2 or below the decoded length, `out_trunc` is 1 and `out_valid`, `out_len`, `out_word` and `out_consume` are all 0.
- R8: `out_consume` equals `out_len` in a cycle where `out_valid` and `out_ready` are both high. In every other cycle it is 0, so no bytes are retired while the consumer stalls.
- R9: While `rst` is high, `out_valid`, `out_trunc`, `out_len` and `out_consume` are 0 whatever the window holds. A count above 6 is treated as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_count | input | 3 | Number of valid bytes in the window (values above 6 treated as 6) |
| in_bytes | input | 48 | Byte window; first stream byte in bits 47:40 |
| out_ready | input | 1 | Consumer accepts the instruction |
| out_valid | output | 1 | A complete instruction is presented |
| out_word | output | 48 | Assembled instruction, right-aligned |
| out_len | output | 3 | Instruction length in bytes (2, 4, 6) or 0 |
| out_class | output | 2 | Target decoder: 0 compact16, 1 compact32, 2 base call, 3 compact48 |
| out_trunc | output | 1 | Too few valid bytes for the instruction |
| out_consume | output | 3 | Bytes to retire from the stream this cycle |

## Verification
Random windows cover all four major-opcode values, both states of the size bit and every sub-opcode, so each length rule is exercised. Random valid counts from 0 to 7, set against each decoded length, separate the truncation cases from exact fits and from over-full windows. Random `out_ready` tells a stalled consumer, which must retire nothing, apart from an accepting one. Directed windows aim at the sub-opcode values 7 and 15 and at the call pattern, and check that the call pattern is told apart from the other 4-byte forms.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

    localparam int HW_BITS   = 16;
    localparam int WIN_BYTES = 6;
    localparam int WIN_BITS  = WIN_BYTES * 8;
    localparam int CNT_W     = $clog2(WIN_BYTES + 1);

    localparam logic [1:0] MAJ_SHORT_OR_WIDE = 2'd0;
    localparam logic [1:0] MAJ_CALL          = 2'd1;
    localparam logic [3:0] SUB_WIDE32        = 4'd7;
    localparam logic [3:0] SUB_WIDE48        = 4'd15;

    typedef enum logic [1:0] {
        CLS_C16    = 2'd0,
        CLS_C32    = 2'd1,
        CLS_BASE32 = 2'd2,
        CLS_C48    = 2'd3
    } ins_class_e;

    typedef struct packed {
        logic [1:0] major;
        logic       wide;
        logic [3:0] sub;
    } head_fields_t;

    function automatic head_fields_t split_head(input logic [HW_BITS-1:0] hw);
        head_fields_t f;
        f.major = hw[15:14];
        f.wide  = hw[9];
        f.sub   = hw[8:5];
        return f;
    endfunction

    function automatic logic [CNT_W-1:0] length_of(input head_fields_t f);
        logic [CNT_W-1:0] n;
        n = CNT_W'(2);
        if (f.major == MAJ_CALL) begin
            n = CNT_W'(4);
        end else if (f.major == MAJ_SHORT_OR_WIDE) begin
            if (f.wide) n = CNT_W'(4);
        end else if (f.sub == SUB_WIDE32) begin
            n = CNT_W'(4);
        end else if (f.sub == SUB_WIDE48) begin
            n = CNT_W'(6);
        end
        return n;
    endfunction

endpackage

// File: rtl/vlp_len_decode.sv
module vlp_len_decode
    import vlp_pkg::*;
(
    input  logic [HW_BITS-1:0] head,
    output logic [CNT_W-1:0]   need
);
    head_fields_t fields;

    always_comb begin
        fields = split_head(head);
        need   = length_of(fields);
    end
endmodule

// File: rtl/vlp_assemble.sv
module vlp_assemble
    import vlp_pkg::*;
(
    input  logic [WIN_BITS-1:0] window,
    input  logic [CNT_W-1:0]    need,
    output logic [WIN_BITS-1:0] word,
    output ins_class_e          cls
);
    localparam int W16 = 16;
    localparam int W32 = 32;

    always_comb begin
        word = '0;
        cls  = CLS_C16;
        case (need)
            CNT_W'(4): begin
                word[W32-1:0] = window[WIN_BITS-1 -: W32];
                cls = (window[WIN_BITS-1 -: 2] == 2'b01) ? CLS_BASE32 : CLS_C32;
            end
            CNT_W'(6): begin
                word = window;
                cls  = CLS_C48;
            end
            default: begin
                word[W16-1:0] = window[WIN_BITS-1 -: W16];
                cls = CLS_C16;
            end
        endcase
    end
endmodule

// File: rtl/vlp_predecode.sv
module vlp_predecode
    import vlp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    in_count,
    input  logic [47:0]   in_bytes,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [47:0]   out_word,
    output logic [2:0]    out_len,
    output logic [1:0]    out_class,
    output logic          out_trunc,
    output logic [2:0]    out_consume
);
    logic [CNT_W-1:0]    need;
    logic [CNT_W-1:0]    avail;
    logic [WIN_BITS-1:0] asm_word;
    ins_class_e          asm_cls;
    logic                enough;

    vlp_len_decode u_len (
        .head (in_bytes[WIN_BITS-1 -: HW_BITS]),
        .need (need)
    );

    vlp_assemble u_asm (
        .window (in_bytes),
        .need   (need),
        .word   (asm_word),
        .cls    (asm_cls)
    );

    always_comb begin
        avail  = (in_count > CNT_W'(WIN_BYTES)) ? CNT_W'(WIN_BYTES) : in_count;
        enough = (avail >= CNT_W'(2)) && (avail >= need);

        out_valid   = 1'b0;
        out_trunc   = 1'b0;
        out_len     = '0;
        out_word    = '0;
        out_class   = CLS_C16;
        out_consume = '0;
        if (!rst) begin
            if (enough) begin
                out_valid = 1'b1;
                out_len   = need;
                out_word  = asm_word;
                out_class = asm_cls;
                if (out_ready) out_consume = need;
            end else begin
                out_trunc = 1'b1;
            end
        end
    end

    AST_TRUNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_trunc |-> (!out_valid && out_len == 3'd0 && out_consume == 3'd0)); // R7

    AST_SHORT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (in_count < 3'd2) |-> out_trunc); // R7

    AST_TAKE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (out_consume != 3'd0) |-> (out_valid && out_ready && out_consume == out_len)); // R8

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len == 3'd2 || out_len == 3'd4 || out_len == 3'd6)); // R3

    AST_CLASS_LEN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((out_class == CLS_C16) == (out_len == 3'd2)) &&
                       ((out_class == CLS_C48) == (out_len == 3'd6)))); // R5

    AST_BASE_CALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == CLS_BASE32) |-> (out_word[31:30] == 2'b01)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (!out_valid && !out_trunc && out_consume == 3'd0)); // R9
endmodule

// File: tb/test_vlp_predecode.sv
`timescale 1ns/1ps
module test_vlp_predecode;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  in_count;
    logic [47:0] in_bytes;
    logic        out_ready;
    logic        out_valid;
    logic [47:0] out_word;
    logic [2:0]  out_len;
    logic [1:0]  out_class;
    logic        out_trunc;
    logic [2:0]  out_consume;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    vlp_predecode i_vlp_predecode (
        .clk(clk), .rst(rst), .in_count(in_count), .in_bytes(in_bytes),
        .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word),
        .out_len(out_len), .out_class(out_class), .out_trunc(out_trunc),
        .out_consume(out_consume)
    );

    task automatic chk(input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int ref_len(input logic [15:0] h);
        if (h[15:14] == 2'd1) return 4;
        if (h[15:14] == 2'd0) return h[9] ? 4 : 2;
        if (h[8:5] == 4'd7) return 4;
        if (h[8:5] == 4'd15) return 6;
        return 2;
    endfunction

    function automatic string len_tag(input logic [15:0] h);
        if (h[15:14] == 2'd1) return "R1";
        if (h[15:14] == 2'd0) return "R2";
        if (h[8:5] == 4'd7 || h[8:5] == 4'd15) return "R3";
        return "R4";
    endfunction

    function automatic logic [1:0] ref_class(input logic [47:0] b, input int n);
        if (n == 2) return 2'd0;
        if (n == 6) return 2'd3;
        return (b[47:46] == 2'b01) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [47:0] ref_word(input logic [47:0] b, input int n);
        if (n == 2) return {32'd0, b[47:32]};
        if (n == 4) return {16'd0, b[47:16]};
        return b;
    endfunction

    task automatic apply(input logic [47:0] b, input int cnt, input bit rdy);
        int n;
        int have;
        bit ok;
        @(negedge clk);
        in_bytes  = b;
        in_count  = 3'(cnt);
        out_ready = rdy;
        #1;
        n    = ref_len(b[47:32]);
        have = (cnt > 6) ? 6 : cnt;
        ok   = (have >= 2) && (have >= n);
        if (ok) begin
            chk(len_tag(b[47:32]), "len", 48'(out_len), 48'(n));
            chk("R5", "class", 48'(out_class), 48'(ref_class(b, n)));
            chk("R6", "word", out_word, ref_word(b, n));
            chk("R7", "valid", 48'(out_valid), 48'd1);
            chk("R7", "trunc", 48'(out_trunc), 48'd0);
            chk("R8", "consume", 48'(out_consume), rdy ? 48'(n) : 48'd0);
        end else begin
            chk("R7", "trunc", 48'(out_trunc), 48'd1);
            chk("R7", "valid", 48'(out_valid), 48'd0);
            chk("R7", "len", 48'(out_len), 48'd0);
            chk("R7", "word", out_word, 48'd0);
            chk("R8", "consume", 48'(out_consume), 48'd0);
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; in_count = 3'd6; in_bytes = 48'h93e9_0000_c350; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R9", "reset valid", 48'(out_valid), 48'd0);
        chk("R9", "reset trunc", 48'(out_trunc), 48'd0);
        chk("R9", "reset consume", 48'(out_consume), 48'd0);
        @(negedge clk);
        rst = 1'b0;

        apply(48'h1005_0000_0000, 2, 1);   // R2 two-byte
        apply(48'h12a8_0061_0000, 4, 1);   // R2 four-byte, compact32
        apply(48'h12a8_0061_0000, 3, 1);   // R7 short by one
        apply(48'h4000_30d4_0000, 4, 1);   // R1 call -> base class (R5)
        apply(48'h4000_30d4_0000, 4, 0);   // R8 stalled, nothing retired
        apply(48'h92f0_061a_0000, 5, 1);   // R3 sub 7
        apply(48'h93e9_0000_c350, 6, 1);   // R3 sub 15, R6 full word
        apply(48'h93e9_0000_c350, 5, 1);   // R7 one byte missing
        apply(48'h93e9_0000_c350, 7, 1);   // R9 count above 6
        apply(48'hbc00_ffff_ffff, 6, 1);   // R4 other sub
        apply(48'h1005_0000_0000, 1, 1);   // R7 fewer than two
        apply(48'h1005_0000_0000, 0, 1);   // R7 empty

        for (int i = 0; i < 4000; i++) begin
            logic [47:0] b;
            b = {16'($urandom), 32'($urandom)};
            if (($urandom % 4) == 0) b[8+32:5+32] = (($urandom % 2) == 0) ? 4'd7 : 4'd15;
            apply(b, int'($urandom % 8), bit'($urandom % 2));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule